// File: doc/BRIEF.md
# Port Pattern-Match Interrupt Unit

This block watches an 8-bit input port and reports when the port shows a pattern set up by software. Three configuration vectors describe each bit: a mask, a transition select and a polarity. Together they choose whether the bit is ignored, must sit at a level, or must make a rising, falling or any edge. A mode input chooses how the per-bit results are combined: disabled, all bits (AND), any bit (OR), or any bit with the highest matching bit number reported (priority vector).

The port is sampled into a register every clock in transparent mode. In latched mode it is sampled only when a capture strobe is high. An edge is found by comparing the current sample with the sample from the clock before. The registered match flag can be read at all times. In AND and OR modes the interrupt request is raised when a match begins, and it stays raised until it is acknowledged. In priority mode the request follows the match level, and the vector output carries the bit number. An interrupt-on-match-only input decides whether latched captures also raise the request.

Top module: `pmatch_unit`

## Requirements
- R1: After reset, match_o, irq_o and vec_o are all zero.
- R2: With mode_i = 2'b00 (disabled), match_o stays low and no match interrupt is raised, whatever the port shows.
- R3: Per-bit code {mask,trans,pol}: {0,0,x} ignores the bit, {1,0,0} needs the bit low and {1,0,1} needs it high. A sample presented before clock edge k is registered at edge k, and its result shows on match_o after edge k+1.
- R4: Code {1,1,1} matches a rising edge, {1,1,0} a falling edge and {0,1,x} either edge. An edge compares the current sample with the previous clock's sample, so it gives a match_o pulse of exactly one cycle.
- R5: In AND mode (mode_i = 2'b01) every non-ignored bit must match. If every bit is ignored, there is no match.
- R6: In OR mode (mode_i = 2'b10) one matching non-ignored bit is enough.
- R7: In AND and OR modes, irq_o rises in the same cycle as match_o when a match begins. It then stays high until ack_i is sampled high. While the match continues it is not raised again.
- R8: In priority mode (mode_i = 2'b11) with transparent sampling, irq_o follows match_o as a level and ack_i has no effect. vec_o gives the highest-numbered matching bit. vec_o is zero whenever match_o is low.
- R9: Priority mode never matches while latch_i = 1.
- R10: With latch_i = 1 the sample changes only on a clock edge where strobe_i is high. Port changes between strobes do not reach match_o.
- R11: With latch_i = 1 and imo_i = 0, every strobe raises irq_o after that edge, even without a match. With imo_i = 1 a strobe raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8 | Port input pins |
| latch_i | input | 1 | 1 = latched sampling, 0 = transparent |
| strobe_i | input | 1 | Capture strobe in latched mode |
| mode_i | input | 2 | 00 off, 01 AND, 10 OR, 11 priority vector |
| mask_i | input | 8 | Per-bit mask |
| trans_i | input | 8 | Per-bit transition select |
| pol_i | input | 8 | Per-bit polarity |
| imo_i | input | 1 | Interrupt on match only |
| ack_i | input | 1 | Clears a pending interrupt |
| match_o | output | 1 | Registered match flag |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 3 | Highest matching bit number in priority mode |

## Verification
The hardest state to reach from the ports is an edge-specified bit that matches in exactly one cycle. The pulse needs the previous sample to be held at the opposite level for at least one clock before the change. The bench therefore holds the port steady for a few cycles before each edge. It then checks match_o both in the cycle after the change and in the cycle after that. A second hard case is a pending interrupt that must outlast a match that is still present. Here the stimulus keeps the level match active, sends the acknowledge, and checks that the request does not come back.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_AND  = 2'b01,
    PM_OR   = 2'b10,
    PM_PRIO = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pm_sampler.sv
module pm_sampler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] port_i,
  input  logic         latch_i,
  input  logic         strobe_i,
  output logic [W-1:0] samp_o,
  output logic [W-1:0] prev_o,
  output logic         cap_o
);
  logic load;
  assign load  = ~latch_i | strobe_i;
  assign cap_o = latch_i & strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      prev_o <= '0;
    end else begin
      prev_o <= samp_o;
      if (load) samp_o <= port_i;
    end
  end
endmodule

// File: rtl/pm_bit_eval.sv
module pm_bit_eval #(
  parameter int W = 8
) (
  input  logic [W-1:0] samp_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] trans_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] care_o,
  output logic [W-1:0] hit_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise, fall;
    assign rise = samp_i[b] & ~prev_i[b];
    assign fall = ~samp_i[b] & prev_i[b];
    always_comb begin
      unique case ({mask_i[b], trans_i[b]})
        2'b00: begin care_o[b] = 1'b0; hit_o[b] = 1'b0; end
        2'b01: begin care_o[b] = 1'b1; hit_o[b] = rise | fall; end
        2'b10: begin care_o[b] = 1'b1; hit_o[b] = pol_i[b] ? samp_i[b] : ~samp_i[b]; end
        default: begin care_o[b] = 1'b1; hit_o[b] = pol_i[b] ? rise : fall; end
      endcase
    end
  end
endmodule

// File: rtl/pm_combine.sv
module pm_combine #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  pm_pkg::pm_mode_e mode_i,
  input  logic             latch_i,
  input  logic [W-1:0]     care_i,
  input  logic [W-1:0]     hit_i,
  output logic             match_o,
  output logic             prio_o,
  output logic [IW-1:0]    idx_o
);
  import pm_pkg::*;
  logic [W-1:0] good;
  logic         all_m, any_m;

  assign good  = care_i & hit_i;
  assign any_m = |good;
  assign all_m = (|care_i) & (&(hit_i | ~care_i));
  assign prio_o = (mode_i == PM_PRIO) & ~latch_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++)
      if (good[i]) idx_o = IW'(i);
  end

  always_comb begin
    unique case (mode_i)
      PM_AND:  match_o = all_m;
      PM_OR:   match_o = any_m;
      PM_PRIO: match_o = any_m & ~latch_i;
      default: match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pm_irq.sv
module pm_irq #(
  parameter int IW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pm_pkg::pm_mode_e mode_i,
  input  logic             match_i,
  input  logic             prio_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             cap_i,
  input  logic             imo_i,
  input  logic             ack_i,
  output logic             match_o,
  output logic [IW-1:0]    vec_o,
  output logic             pend_o,
  output logic             irq_o
);
  import pm_pkg::*;
  logic prio_q, edge_mode, set_pend;

  assign edge_mode = (mode_i == PM_AND) | (mode_i == PM_OR);
  assign set_pend  = (edge_mode & match_i & ~match_o) | (cap_i & ~imo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      vec_o   <= '0;
      prio_q  <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      match_o <= match_i;
      vec_o   <= (match_i & prio_i) ? idx_i : '0;
      prio_q  <= prio_i;
      pend_o  <= set_pend | (pend_o & ~ack_i);
    end
  end

  assign irq_o = pend_o | (prio_q & match_o);
endmodule

// File: rtl/pmatch_unit.sv
module pmatch_unit #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  port_i,
  input  logic          latch_i,
  input  logic          strobe_i,
  input  logic [1:0]    mode_i,
  input  logic [W-1:0]  mask_i,
  input  logic [W-1:0]  trans_i,
  input  logic [W-1:0]  pol_i,
  input  logic          imo_i,
  input  logic          ack_i,
  output logic          match_o,
  output logic          irq_o,
  output logic [IW-1:0] vec_o
);
  import pm_pkg::*;
  pm_mode_e     mode;
  logic [W-1:0] samp, prev, care, hit;
  logic         cap, match_n, prio_n, pend;
  logic [IW-1:0] idx;

  assign mode = pm_mode_e'(mode_i);

  pm_sampler #(.W(W)) u_samp (
    .clk_i, .rst_ni, .port_i, .latch_i, .strobe_i,
    .samp_o(samp), .prev_o(prev), .cap_o(cap)
  );

  pm_bit_eval #(.W(W)) u_bits (
    .samp_i(samp), .prev_i(prev), .mask_i, .trans_i, .pol_i,
    .care_o(care), .hit_o(hit)
  );

  pm_combine #(.W(W), .IW(IW)) u_comb (
    .mode_i(mode), .latch_i, .care_i(care), .hit_i(hit),
    .match_o(match_n), .prio_o(prio_n), .idx_o(idx)
  );

  pm_irq #(.IW(IW)) u_irq (
    .clk_i, .rst_ni, .mode_i(mode), .match_i(match_n), .prio_i(prio_n),
    .idx_i(idx), .cap_i(cap), .imo_i, .ack_i,
    .match_o, .vec_o, .pend_o(pend), .irq_o
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic          latch_i,
  input logic          ack_i,
  input logic          match_o,
  input logic          irq_o,
  input logic [IW-1:0] vec_o,
  input logic          pend
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> !match_o);                                  // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !ack_i) |=> pend);                                       // R7
  AST_PRIO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !latch_i) |=> (!match_o || irq_o));           // R8
  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (vec_o == '0));                                      // R8
  AST_LATCH_NO_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && latch_i) |=> !match_o);                       // R9
endmodule

bind pmatch_unit pm_checker #(.IW(IW)) i_pm_checker (
  .clk_i, .rst_ni, .mode_i, .latch_i, .ack_i,
  .match_o, .irq_o, .vec_o, .pend(pend)
);

// File: tb/test_pmatch_unit.sv
module test_pmatch_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port_i = '0, mask_i = '0, trans_i = '0, pol_i = '0;
  logic       latch_i = 1'b0, strobe_i = 1'b0, imo_i = 1'b1, ack_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       match_o, irq_o;
  logic [2:0] vec_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  pmatch_unit i_pmatch_unit (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic clear_irq();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 match", match_o, 0); chk("R1 irq", irq_o, 0); chk("R1 vec", vec_o, 0);
  endtask

  task automatic t_disabled();
    mode_i = 2'b00; mask_i = 8'hFF; trans_i = 8'h00; pol_i = 8'hFF; port_i = 8'hFF;
    step(3);
    chk("R2 match", match_o, 0); chk("R2 irq", irq_o, 0);
    port_i = 8'h00; step(3);
  endtask

  task automatic t_and_level();
    mode_i = 2'b01; mask_i = 8'h03; trans_i = 8'h00; pol_i = 8'h01; port_i = 8'h00;
    step(3); clear_irq();
    port_i = 8'h01; step(1);
    chk("R3 latency", match_o, 0);
    step(1);
    chk("R3 level match", match_o, 1);
    chk("R7 irq on rise", irq_o, 1);
    step(3);
    chk("R7 irq held", irq_o, 1);
    clear_irq(); step(2);
    chk("R7 no rearm", irq_o, 0);
    chk("R7 match stays", match_o, 1);
    port_i = 8'h03; step(2);
    chk("R5 AND partial", match_o, 0);
    mask_i = 8'h00; port_i = 8'h00; step(3);
    chk("R5 AND empty", match_o, 0);
  endtask

  task automatic t_or();
    mode_i = 2'b10; mask_i = 8'h30; trans_i = 8'h00; pol_i = 8'h30; port_i = 8'h00;
    step(3); clear_irq();
    port_i = 8'h10; step(2);
    chk("R6 OR one bit", match_o, 1);
    chk("R6 OR irq", irq_o, 1);
    port_i = 8'h00; step(2); clear_irq();
  endtask

  task automatic t_edges();
    mode_i = 2'b10; mask_i = 8'h01; trans_i = 8'h01; pol_i = 8'h01; port_i = 8'h00;
    step(3);
    port_i = 8'h01; step(2);
    chk("R4 rise pulse", match_o, 1);
    step(1);
    chk("R4 rise one cycle", match_o, 0);
    pol_i = 8'h00; step(2);
    port_i = 8'h00; step(2);
    chk("R4 fall pulse", match_o, 1);
    step(1);
    chk("R4 fall one cycle", match_o, 0);
    mask_i = 8'h00; trans_i = 8'h08; step(2);
    port_i = 8'h08; step(2);
    chk("R4 any edge up", match_o, 1);
    step(1); port_i = 8'h00; step(2);
    chk("R4 any edge down", match_o, 1);
    step(1);
    chk("R4 any edge one cycle", match_o, 0);
    clear_irq(); trans_i = 8'h00;
  endtask

  task automatic t_prio();
    mode_i = 2'b11; latch_i = 1'b0; mask_i = 8'hFF; trans_i = 8'h00; pol_i = 8'hFF;
    port_i = 8'h00; step(3); clear_irq();
    port_i = 8'h26; step(2);
    chk("R8 vec", vec_o, 5); chk("R8 irq level", irq_o, 1);
    clear_irq();
    chk("R8 ack ignored", irq_o, 1);
    port_i = 8'h81; step(2);
    chk("R8 vec top", vec_o, 7);
    port_i = 8'h00; step(2);
    chk("R8 irq drops", irq_o, 0); chk("R8 vec zero", vec_o, 0);
  endtask

  task automatic t_latched();
    imo_i = 1'b1; latch_i = 1'b1; mode_i = 2'b11; mask_i = 8'hFF; pol_i = 8'hFF;
    port_i = 8'h00; strobe_i = 1'b1; step(1); strobe_i = 1'b0;
    port_i = 8'h04; strobe_i = 1'b1; step(1); strobe_i = 1'b0; step(2);
    chk("R9 prio blocked", match_o, 0);
    mode_i = 2'b10; mask_i = 8'h04; pol_i = 8'h04; port_i = 8'h00;
    strobe_i = 1'b1; step(1); strobe_i = 1'b0; step(2); clear_irq();
    port_i = 8'h04; step(3);
    chk("R10 no strobe", match_o, 0);
    chk("R11 imo quiet", irq_o, 0);
    strobe_i = 1'b1; step(1); strobe_i = 1'b0; step(1);
    chk("R10 strobe match", match_o, 1);
    clear_irq();
    mode_i = 2'b00; imo_i = 1'b0;
    strobe_i = 1'b1; step(1); strobe_i = 1'b0;
    chk("R11 capture irq", irq_o, 1);
    clear_irq(); imo_i = 1'b1; latch_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        step(2); rst_ni = 1'b1; step(1);
        t_reset(); t_disabled(); t_and_level(); t_or(); t_edges(); t_prio(); t_latched();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule